// File: doc/BRIEF.md
# Fetch Redirect and Branch Recovery Unit

This block picks the next fetch address for a two-stage front end (fetch, then decode) and repairs the front end when that pick turns out wrong. In the fetch cycle it looks at the current fetch address, the lookup result from an external branch target buffer (hit flag and stored target), and its own table of 2-bit direction counters. From these it forms a predicted next address: the stored target when the buffer hits and the counter says taken, otherwise the sequential address (fetch address + 4).

The prediction travels in the fetch/decode pipeline register together with the fetch address. In the decode cycle the block resolves the instruction. A conditional branch is taken when its two register operands are equal, and its target is its own address + 4 + the sign-extended 16-bit immediate shifted left by two. The block then compares both the guessed direction and the guessed next address with the resolved ones. A wrong direction, or a right direction with a wrong stored target, raises one shared redirect. That redirect kills the instruction now being fetched and loads the fetch address with the correct one. The same decode cycle trains the counter of the branch and, for taken branches, offers a write to the external target buffer. A killed instruction reaches decode as a bubble and has no effect.

Top module: `fetch_redirect_unit`

## Requirements
- R1: While reset is asserted, fetch_pc equals RESET_PC (default 0), dec_valid is 0, and redirect_valid, nullify_fetch and tbw_en are 0.
- R2: When no redirect is raised and tb_hit is 0, the next fetch_pc is the current fetch_pc + 4.
- R3: When tb_hit is 1 and the direction counter selected by the fetch address predicts taken, the next fetch_pc is tb_target. When that counter predicts not taken, the next fetch_pc is fetch_pc + 4.
- R4: A valid decode instruction with dec_is_branch = 1 resolves taken exactly when dec_rs_val equals dec_rt_val. Its taken target is dec_pc + 4 + ({sign-extended dec_imm} << 2), and its not-taken successor is dec_pc + 4.
- R5: When a valid decode branch resolves in the direction opposite to its prediction, redirect_valid and nullify_fetch are 1 and redirect_pc is the resolved successor.
- R6: When a valid decode branch resolves in the predicted direction but the address fetched after it differs from the resolved successor, redirect_valid and nullify_fetch are 1 and redirect_pc is the resolved successor.
- R7: A valid decode instruction with dec_is_branch = 0 whose fetch followed a taken prediction to an address other than dec_pc + 4 is redirected to dec_pc + 4. The predictor output has no other effect on it.
- R8: Each of the TABLE_DEPTH (default 128) counters is 2 bits wide and resets to 01. A counter predicts taken when its value is 2 or 3. It is indexed by address bits [IDX_W+1:2]. It is read with the fetch address and written, for every valid decode branch, at the branch's index. It counts up on taken and down on not taken, and it saturates at 3 and at 0. A write becomes visible to reads from the next cycle on.
- R9: tbw_en is 1 exactly when a valid decode branch resolves taken. In that cycle tbw_pc is dec_pc and tbw_target is the taken target.
- R10: In the cycle after a redirect, dec_valid is 0. Whatever the decode inputs are, that bubble causes no redirect, no counter update and no tbw_en.
- R11: In the cycle after a redirect, fetch_pc equals the redirect_pc of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tb_hit | input | 1 | Target buffer lookup for fetch_pc hit |
| tb_target | input | XLEN | Stored target from the target buffer |
| dec_is_branch | input | 1 | Decoder flags the decode instruction as a conditional branch |
| dec_rs_val | input | XLEN | First compared register operand of the decode instruction |
| dec_rt_val | input | XLEN | Second compared register operand of the decode instruction |
| dec_imm | input | IMM_W | Branch immediate of the decode instruction |
| fetch_pc | output | XLEN | Address being fetched this cycle |
| dec_valid | output | 1 | Decode slot holds a live (not killed) instruction |
| dec_pc | output | XLEN | Address of the instruction in decode |
| nullify_fetch | output | 1 | Kill the instruction being fetched this cycle |
| redirect_valid | output | 1 | Override the next fetch address |
| redirect_pc | output | XLEN | Corrected next fetch address |
| tbw_en | output | 1 | Write request for the target buffer |
| tbw_pc | output | XLEN | Branch address to tag the write |
| tbw_target | output | XLEN | Target to store |

## Verification
The embedded properties check the invariants of every cycle. A live decode slot always sits behind a fetch address equal to its carried prediction. A redirect is always followed by a bubble and by the redirected address. Fetch without a hit steps by four. The target-buffer write appears only for live taken branches, and counters stay pinned at their saturation limits. Only the bench's scenarios can show the sequences that need history: a loop branch training its counter from weakly not-taken into correct prediction, a stale stored target detected as a target error after a correct direction, a buffer hit on a non-branch, and a branch that stops being taken. Only the bench's model, run over a long random phase, can confirm that every counter value and redirect address matches the resolved outcome.

// File: rtl/frd_pkg.sv
package frd_pkg;

  // 2-bit saturating direction counter
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;  // weakly not-taken
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  // Reason for a redirect raised in decode
  typedef enum logic [1:0] {
    RC_NONE  = 2'd0,
    RC_DIR   = 2'd1,   // direction guessed wrong
    RC_TGT   = 2'd2,   // direction right, address wrong
    RC_NOTBR = 2'd3    // non-branch followed a taken guess
  } redirect_cause_e;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/frd_dir_table.sv
module frd_dir_table
  import frd_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  ctr_t ctr_q [DEPTH];

  // One counter per entry; the read sees the value before this cycle's write
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctr_q[e] <= CTR_RESET;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ctr_q[e] <= ctr_next(ctr_q[e], wr_taken);
      end
    end
  end

  assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);

  // Named events for the checks below
  ctr_t wr_old;
  logic sat_hi_evt;
  logic sat_lo_evt;
  assign wr_old     = ctr_q[wr_idx];
  assign sat_hi_evt = wr_en && wr_taken  && (wr_old == CTR_MAX);
  assign sat_lo_evt = wr_en && !wr_taken && (wr_old == CTR_MIN);

  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi_evt |=> ctr_q[$past(wr_idx)] == CTR_MAX);  // R8
  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo_evt |=> ctr_q[$past(wr_idx)] == CTR_MIN);  // R8

endmodule

// File: rtl/frd_next_pc.sv
module frd_next_pc #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 7
) (
  input  logic [XLEN-1:0]  fetch_pc,
  input  logic             tb_hit,
  input  logic [XLEN-1:0]  tb_target,
  input  logic             ctr_taken,
  output logic [IDX_W-1:0] rd_idx,
  output logic             pred_taken,
  output logic [XLEN-1:0]  pred_npc
);

  function automatic logic [XLEN-1:0] seq_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  // Counter index comes from the word-address bits above the byte offset
  assign rd_idx = fetch_pc[IDX_W+1:2];

  // A buffer hit stands for "this is a branch"; without it the counter is ignored
  always_comb begin
    pred_taken = tb_hit && ctr_taken;
    pred_npc   = pred_taken ? tb_target : seq_pc(fetch_pc);
  end

endmodule

// File: rtl/frd_resolve.sv
module frd_resolve
  import frd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fd_valid,
  input  logic [XLEN-1:0]  fd_pc,
  input  logic             fd_pred_taken,
  input  logic [XLEN-1:0]  fd_pred_npc,
  input  logic             is_branch,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMM_W-1:0] imm,
  output logic             br_valid,
  output logic             br_taken,
  output logic [XLEN-1:0]  br_target,
  output logic             redirect,
  output logic [XLEN-1:0]  redirect_pc,
  output redirect_cause_e  cause
);

  function automatic logic [XLEN-1:0] imm_offset(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W-2){v[IMM_W-1]}}, v, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] taken_target(input logic [XLEN-1:0] pc,
                                                   input logic [IMM_W-1:0] v);
    return pc + XLEN'(4) + imm_offset(v);
  endfunction

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] correct_npc;
  logic            dir_wrong;
  logic            addr_wrong;

  always_comb begin
    br_valid    = fd_valid && is_branch;
    br_taken    = br_valid && (rs_val == rt_val);
    seq_pc      = fd_pc + XLEN'(4);
    br_target   = taken_target(fd_pc, imm);
    correct_npc = br_taken ? br_target : seq_pc;
    dir_wrong   = br_valid && (br_taken != fd_pred_taken);
    // Covers a stale target on a correct guess and a hit on a non-branch
    addr_wrong  = fd_valid && !dir_wrong && (fd_pred_npc != correct_npc);
    redirect    = dir_wrong || addr_wrong;
    redirect_pc = correct_npc;
    if (dir_wrong)                   cause = RC_DIR;
    else if (addr_wrong && br_valid) cause = RC_TGT;
    else if (addr_wrong)             cause = RC_NOTBR;
    else                             cause = RC_NONE;
  end

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fd_valid |-> (!redirect && !br_valid));  // R10
  AST_NOTBR_TO_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == RC_NOTBR) |-> (redirect_pc == fd_pc + XLEN'(4)));  // R7

endmodule

// File: rtl/fetch_redirect_unit.sv
module fetch_redirect_unit
  import frd_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              IMM_W       = 16,
  parameter int              TABLE_DEPTH = 128,
  parameter logic [XLEN-1:0] RESET_PC    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_hit,
  input  logic [XLEN-1:0]  tb_target,
  input  logic             dec_is_branch,
  input  logic [XLEN-1:0]  dec_rs_val,
  input  logic [XLEN-1:0]  dec_rt_val,
  input  logic [IMM_W-1:0] dec_imm,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             dec_valid,
  output logic [XLEN-1:0]  dec_pc,
  output logic             nullify_fetch,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc,
  output logic             tbw_en,
  output logic [XLEN-1:0]  tbw_pc,
  output logic [XLEN-1:0]  tbw_target
);

  localparam int IDX_W = $clog2(TABLE_DEPTH);

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] pc;
    logic            pred_taken;
    logic [XLEN-1:0] pred_npc;
  } fd_reg_t;

  logic [XLEN-1:0]  pc_q;
  fd_reg_t          fd_q;

  // Fetch-stage wires
  logic [IDX_W-1:0] rd_idx;
  logic             ctr_taken;
  logic             pred_taken;
  logic [XLEN-1:0]  pred_npc;

  // Decode-stage wires
  logic             br_valid;
  logic             br_taken;
  logic [XLEN-1:0]  br_target;
  logic             redirect;
  logic [XLEN-1:0]  fix_pc;
  redirect_cause_e  cause;

  frd_dir_table #(.DEPTH(TABLE_DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_taken (ctr_taken),
    .wr_en    (br_valid),
    .wr_idx   (fd_q.pc[IDX_W+1:2]),
    .wr_taken (br_taken)
  );

  frd_next_pc #(.XLEN(XLEN), .IDX_W(IDX_W)) u_next (
    .fetch_pc   (pc_q),
    .tb_hit     (tb_hit),
    .tb_target  (tb_target),
    .ctr_taken  (ctr_taken),
    .rd_idx     (rd_idx),
    .pred_taken (pred_taken),
    .pred_npc   (pred_npc)
  );

  frd_resolve #(.XLEN(XLEN), .IMM_W(IMM_W)) u_resolve (
    .clk           (clk),
    .rst_n         (rst_n),
    .fd_valid      (fd_q.valid),
    .fd_pc         (fd_q.pc),
    .fd_pred_taken (fd_q.pred_taken),
    .fd_pred_npc   (fd_q.pred_npc),
    .is_branch     (dec_is_branch),
    .rs_val        (dec_rs_val),
    .rt_val        (dec_rt_val),
    .imm           (dec_imm),
    .br_valid      (br_valid),
    .br_taken      (br_taken),
    .br_target     (br_target),
    .redirect      (redirect),
    .redirect_pc   (fix_pc),
    .cause         (cause)
  );

  // PC register: a decode redirect overrides the fetch-stage prediction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= redirect ? fix_pc : pred_npc;
    end
  end

  // Fetch/decode register: a killed fetch enters decode as a bubble
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd_q <= '0;
    end else begin
      fd_q.valid      <= !redirect;
      fd_q.pc         <= pc_q;
      fd_q.pred_taken <= pred_taken;
      fd_q.pred_npc   <= pred_npc;
    end
  end

  assign fetch_pc       = pc_q;
  assign dec_valid      = fd_q.valid;
  assign dec_pc         = fd_q.pc;
  assign nullify_fetch  = redirect;
  assign redirect_valid = redirect;
  assign redirect_pc    = fix_pc;
  assign tbw_en         = br_taken;
  assign tbw_pc         = fd_q.pc;
  assign tbw_target     = br_target;

  AST_FETCH_FOLLOWS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> fetch_pc == fd_q.pred_npc);  // R3
  AST_REDIRECT_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> fetch_pc == $past(redirect_pc));  // R11
  AST_REDIRECT_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !dec_valid);  // R10
  AST_SEQ_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !tb_hit) |=> fetch_pc == $past(fetch_pc) + XLEN'(4));  // R2
  AST_TBW_TAKEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tbw_en |-> (dec_valid && dec_is_branch && (dec_rs_val == dec_rt_val)));  // R9
  AST_CAUSE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (cause != RC_NONE));  // R5

endmodule

// File: tb/fetch_redirect_unit_tb_top.sv
module fetch_redirect_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam logic [31:0] RST_PC = 32'h0;

  logic        clk;
  logic        rst_n;
  logic        tb_hit;
  logic [31:0] tb_target;
  logic        dec_is_branch;
  logic [31:0] dec_rs_val;
  logic [31:0] dec_rt_val;
  logic [15:0] dec_imm;
  logic [31:0] fetch_pc;
  logic        dec_valid;
  logic [31:0] dec_pc;
  logic        nullify_fetch;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        tbw_en;
  logic [31:0] tbw_pc;
  logic [31:0] tbw_target;

  fetch_redirect_unit #(
    .XLEN(32), .IMM_W(16), .TABLE_DEPTH(DEPTH), .RESET_PC(RST_PC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_hit(tb_hit), .tb_target(tb_target),
    .dec_is_branch(dec_is_branch), .dec_rs_val(dec_rs_val),
    .dec_rt_val(dec_rt_val), .dec_imm(dec_imm), .fetch_pc(fetch_pc),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .nullify_fetch(nullify_fetch),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .tbw_en(tbw_en), .tbw_pc(tbw_pc), .tbw_target(tbw_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Behavioural reference state
  int          ctr [DEPTH];
  logic [31:0] m_pc;
  bit          m_fv;
  logic [31:0] m_fpc;
  bit          m_fpt;
  logic [31:0] m_fnpc;
  string       m_lbl;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (fetch model pc %h)",
               req, what, act, exp, m_pc);
    end
  endtask

  function automatic int tidx(input logic [31:0] pc);
    return int'(pc >> 2) % DEPTH;
  endfunction

  // Scenario stimulus; uses the model's view of the fetch and decode addresses
  task automatic drive(input int mode);
    tb_hit = 0; tb_target = 0; dec_is_branch = 0;
    dec_rs_val = 5; dec_rt_val = 5; dec_imm = 0;
    case (mode)
      1, 2, 3: begin  // loop branch at 0x40 back to 0x20
        tb_hit        = (m_pc == 32'h40);
        tb_target     = (mode == 3) ? 32'h30 : 32'h20;
        dec_is_branch = (m_fpc == 32'h40);
        dec_imm       = 16'hFFF7;          // -9 words
        if (mode == 2) dec_rt_val = 6;     // stops being taken
      end
      5, 6: begin  // 0x10 -> 0x80 (mode 5 only), 0x9C -> 0x10 always
        tb_hit    = (m_pc == 32'h10);
        tb_target = 32'h80;
        if (m_fpc == 32'h10 && mode == 5) begin
          dec_is_branch = 1; dec_imm = 16'd27;
        end else if (m_fpc == 32'h9C) begin
          dec_is_branch = 1; dec_imm = 16'hFFDC;  // -36 words
        end
      end
      9: begin
        tb_hit        = ($urandom_range(0, 9) < 4);
        tb_target     = {22'd0, 8'($urandom_range(0, 255)), 2'b00};
        dec_is_branch = ($urandom_range(0, 9) < 6);
        dec_rs_val    = $urandom_range(0, 1);
        dec_rt_val    = $urandom_range(0, 1);
        dec_imm       = 16'($urandom_range(0, 63) - 32);
      end
      default: ;
    endcase
  endtask

  // One cycle: entered at a falling edge, left at the next falling edge
  task automatic step(input int mode);
    bit          pt, bv, tk, dw, tw, red, hit_now;
    logic [31:0] pn, bt, cn;
    string       rl;
    drive(mode);
    #1;
    hit_now = tb_hit;
    pt = tb_hit && (ctr[tidx(m_pc)] >= 2);
    pn = pt ? tb_target : m_pc + 32'd4;
    bv = m_fv && dec_is_branch;
    tk = bv && (dec_rs_val == dec_rt_val);
    bt = m_fpc + 32'd4 + 32'($signed(dec_imm) * 4);
    cn = tk ? bt : m_fpc + 32'd4;
    dw = bv && (tk != m_fpt);
    tw = m_fv && !dw && (m_fnpc != cn);
    red = dw || tw;

    check(m_lbl, "fetch_pc", fetch_pc, m_pc);
    check("R10", "dec_valid", {31'd0, dec_valid}, {31'd0, m_fv});
    if (dw)      rl = "R5";
    else if (tw) rl = bv ? "R6" : "R7";
    else if (!m_fv) rl = "R10";
    else         rl = "R4";
    check(rl, "redirect_valid", {31'd0, redirect_valid}, {31'd0, red});
    check(rl, "nullify_fetch", {31'd0, nullify_fetch}, {31'd0, red});
    if (red) check(tk ? "R4" : rl, "redirect_pc", redirect_pc, cn);
    check("R9", "tbw_en", {31'd0, tbw_en}, {31'd0, tk});
    if (tk) begin
      check("R9", "tbw_pc", tbw_pc, m_fpc);
      check("R9", "tbw_target", tbw_target, bt);
    end

    @(posedge clk);
    if (bv) begin  // R8 counter training in the model
      if (tk) ctr[tidx(m_fpc)] = (ctr[tidx(m_fpc)] == 3) ? 3 : ctr[tidx(m_fpc)] + 1;
      else    ctr[tidx(m_fpc)] = (ctr[tidx(m_fpc)] == 0) ? 0 : ctr[tidx(m_fpc)] - 1;
    end
    if (red)          m_lbl = "R11";
    else if (pt)      m_lbl = "R3";
    else if (hit_now) m_lbl = "R8";
    else              m_lbl = "R2";
    m_fv   = !red;
    m_fpc  = m_pc;
    m_fpt  = pt;
    m_fnpc = pn;
    m_pc   = red ? cn : pn;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ctr[i] = 1;
    m_pc = RST_PC; m_fv = 0; m_fpc = 0; m_fpt = 0; m_fnpc = 0; m_lbl = "R2";
    rst_n = 0;
    drive(9);  // busy decode inputs during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset fetch_pc", fetch_pc, RST_PC);
    check("R1", "reset dec_valid", {31'd0, dec_valid}, 32'd0);
    check("R1", "reset redirect", {31'd0, redirect_valid}, 32'd0);
    check("R1", "reset nullify", {31'd0, nullify_fetch}, 32'd0);
    check("R1", "reset tbw_en", {31'd0, tbw_en}, 32'd0);
    rst_n = 1;

    repeat (12)   step(0);  // sequential fetch, R2
    repeat (60)   step(1);  // loop trains counter, R3 R5 R8
    repeat (20)   step(3);  // stale stored target, R6
    repeat (20)   step(1);
    repeat (10)   step(2);  // branch turns not taken, R5
    repeat (80)   step(5);  // second loop, R5 R9
    repeat (60)   step(6);  // hit on a non-branch, R7
    repeat (3000) step(9);  // random mix, R4 R10

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule